// File: doc/BRIEF.md
# Framebuffer Scan Address Generator

This block produces the memory read addresses used to fetch framebuffer pixels while a panel is being scanned out. It takes a frame configuration (buffer base, active width and height, vertical total, pixel depth, a grey-scale packing flag, a rotate request and a dual-scan flag), together with frame-start, line-start and fetch-step strobes from the display timing generator. From these it derives the line pitch and the first fetch address, then walks one address for the upper panel half and, on split dual-scan panels, a second address for the lower half.

Two scan orders are supported. In the normal order, addresses rise along a line and each new line begins one pitch further on. In the rotated order, the pitch is taken from the vertical total and rounded up to a power of two. The walk starts at the last buffer line and steps backwards one pitch per fetch. Configuration is sampled on frame start and checked once. A misaligned base or an oversized buffer parks the block in a fault state, and no addresses are issued until the next frame start.

A control state machine sequences each frame. Its states are ST_IDLE (after reset), ST_LOAD (one cycle, origin computed and walkers loaded), ST_SCAN (addresses valid) and ST_FAULT (configuration rejected). Its transitions are IDLE→LOAD on frame start, LOAD→SCAN when the configuration is acceptable, LOAD→FAULT when it is not, LOAD→LOAD on a repeated frame start, and SCAN→LOAD and FAULT→LOAD on frame start.

Top module: `fb_scan_addr`

## Requirements
- R1: Pitch in normal order equals the active width times bytes per pixel, where cfg_depth codes 0, 1, 2 and 3 (1, 2, 4 and 8/6 bpp) use one byte per pixel and code 4 (16 bpp, also codes 5 to 7) uses two bytes.
- R2: With cfg_gray set, pixels share bytes: code 0 divides the pixel count by 8, code 1 by 4, code 2 by 2, and code 3 (covering 6 bpp) keeps one byte per pixel.
- R3: In rotated order the pitch is computed as in R1/R2 from cfg_vtotal instead of the width, then rounded up to the next power of two if it is not already one.
- R4: A rotate request has no effect when cfg_width exceeds 320; rot_active stays 0 and the normal pitch and start apply.
- R5: In rotated order the first upper address is cfg_base + (cfg_width − 1) × pitch; in normal order it is cfg_base.
- R6: With cfg_dual set, the first lower address is the first upper address plus pitch × (height/2), or pitch × (width/2) when rotated; with cfg_dual clear lower_addr is 0.
- R7: A base whose low 9 bits are not all zero raises err_misalign, holds addr_valid low and forces both addresses and line_pitch to 0.
- R8: When pitch × lines (height, or width when rotated) exceeds 2,097,152 bytes, err_oversize is raised with the same suppression as R7; exactly 2,097,152 is accepted.
- R9: In normal order a fetch step adds 4 to both addresses and a line start sets each to its line origin plus one pitch.
- R10: In rotated order a fetch step subtracts one pitch from both addresses and a line start sets each to its line origin plus 4.
- R11: Frame start outranks line start, which outranks fetch step, when they coincide in one cycle.
- R12: After reset all outputs are 0; addresses become valid on the second rising edge after frame start is sampled, holding the first fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 32 | Framebuffer base byte address |
| cfg_width | input | 11 | Active pixels per line |
| cfg_height | input | 11 | Active lines per frame |
| cfg_vtotal | input | 11 | Vertical total in lines (rotated pitch source) |
| cfg_depth | input | 3 | Pixel depth code (see R1) |
| cfg_gray | input | 1 | Grey-scale packing of sub-byte depths |
| cfg_rotate | input | 1 | Rotated scan request |
| cfg_dual | input | 1 | Dual-scan split panel present |
| frame_start | input | 1 | Frame start strobe; samples configuration |
| line_start | input | 1 | Line start strobe |
| fetch_step | input | 1 | Advance to the next fetch within the line |
| upper_addr | output | 32 | Upper-panel fetch address |
| lower_addr | output | 32 | Lower-panel fetch address |
| addr_valid | output | 1 | Addresses valid (scanning) |
| line_pitch | output | 16 | Pitch in bytes in use |
| rot_active | output | 1 | Rotated order in effect |
| err_misalign | output | 1 | Base alignment fault |
| err_oversize | output | 1 | Buffer size fault |

## Verification
Line start and fetch step can arrive in the same cycle, and so can frame start and line start. The bench raises both strobes on one negative edge during a scan. It then judges the addresses after the following rising edge against the line-advance value only, which excludes the fetch increment. It also checks that a coincident frame start drops addr_valid and reloads the first address two edges later.

// File: rtl/fbsa_pkg.sv
package fbsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SCAN  = 2'd2,
        ST_FAULT = 2'd3
    } fbsa_state_e;

    typedef enum logic [2:0] {
        DEPTH_1  = 3'd0,
        DEPTH_2  = 3'd1,
        DEPTH_4  = 3'd2,
        DEPTH_8  = 3'd3,
        DEPTH_16 = 3'd4
    } fbsa_depth_e;

endpackage

// File: rtl/fbsa_pitch.sv
module fbsa_pitch #(
    parameter int DIM_W     = 11,
    parameter int PITCH_W   = 16,
    parameter int ROT_LIMIT = 320
) (
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   vtotal,
    input  logic [2:0]         depth,
    input  logic               gray,
    input  logic               rotate_req,
    output logic               rot_eff,
    output logic [PITCH_W-1:0] pitch
);
    import fbsa_pkg::*;

    localparam int TB_W = $clog2(PITCH_W) + 1;

    logic [PITCH_W-1:0] span;
    logic [PITCH_W-1:0] packed_b;
    logic [PITCH_W-1:0] rounded;
    logic [TB_W-1:0]    top_bit;
    logic               is_pow2;

    assign rot_eff = rotate_req && (int'(width) <= ROT_LIMIT);
    assign span    = PITCH_W'(rot_eff ? vtotal : width);

    // bytes per line from pixel count, depth code and packing
    always_comb begin
        unique case (depth)
            DEPTH_1: packed_b = gray ? (span >> 3) : span;
            DEPTH_2: packed_b = gray ? (span >> 2) : span;
            DEPTH_4: packed_b = gray ? (span >> 1) : span;
            DEPTH_8: packed_b = span;
            default: packed_b = span << 1;
        endcase
    end

    // highest set bit, for rounding up to a power of two
    always_comb begin
        top_bit = '0;
        for (int i = 0; i < PITCH_W; i++) begin
            if (packed_b[i]) top_bit = TB_W'(i);
        end
    end

    assign is_pow2 = ($countones(packed_b) <= 1);
    assign rounded = is_pow2 ? packed_b : (PITCH_W'(1) << (top_bit + TB_W'(1)));
    assign pitch   = rot_eff ? rounded : packed_b;

endmodule

// File: rtl/fbsa_origin.sv
module fbsa_origin #(
    parameter int ADDR_W     = 32,
    parameter int DIM_W      = 11,
    parameter int PITCH_W    = 16,
    parameter int ALIGN_BITS = 9,
    parameter int MAX_BYTES  = 2097152
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   height,
    input  logic [PITCH_W-1:0] pitch,
    input  logic               rot,
    input  logic               dual,
    output logic [ADDR_W-1:0]  start_up,
    output logic [ADDR_W-1:0]  start_lo,
    output logic               misalign,
    output logic               oversize
);
    localparam int PROD_W = PITCH_W + DIM_W;
    localparam logic [PROD_W:0] LIMIT = (PROD_W + 1)'(MAX_BYTES);

    logic [DIM_W-1:0]  lines;
    logic [PROD_W-1:0] last_off;
    logic [PROD_W-1:0] half_off;
    logic [PROD_W-1:0] frame_bytes;

    // lines in the buffer: columns become lines when rotated
    assign lines       = rot ? width : height;
    assign last_off    = PROD_W'(pitch) * PROD_W'(width - DIM_W'(1));
    assign half_off    = PROD_W'(pitch) * PROD_W'(lines >> 1);
    assign frame_bytes = PROD_W'(pitch) * PROD_W'(lines);

    assign start_up = base + (rot ? ADDR_W'(last_off) : '0);
    assign start_lo = dual ? (start_up + ADDR_W'(half_off)) : '0;
    assign misalign = |base[ALIGN_BITS-1:0];
    assign oversize = {1'b0, frame_bytes} > LIMIT;

endmodule

// File: rtl/fbsa_walker.sv
module fbsa_walker #(
    parameter int ADDR_W     = 32,
    parameter int PITCH_W    = 16,
    parameter int STEP_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  origin,
    input  logic               advance_line,
    input  logic               advance_fetch,
    input  logic               reverse,
    input  logic [PITCH_W-1:0] pitch,
    output logic [ADDR_W-1:0]  addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    logic [ADDR_W-1:0] line_ptr;
    logic [ADDR_W-1:0] line_inc;
    logic [ADDR_W-1:0] pitch_w;

    assign pitch_w  = ADDR_W'(pitch);
    assign line_inc = reverse ? STEP : pitch_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_ptr <= '0;
            addr     <= '0;
        end else if (load) begin
            line_ptr <= origin;
            addr     <= origin;
        end else if (advance_line) begin
            line_ptr <= line_ptr + line_inc;
            addr     <= line_ptr + line_inc;
        end else if (advance_fetch) begin
            addr     <= reverse ? (addr - pitch_w) : (addr + STEP);
        end
    end

    // R12: a load places the origin on the output at the next edge
    a_r12_load_origin: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(origin));

    // R9/R10: with no strobe the address holds
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance_line && !advance_fetch) |=> $stable(addr));

    // R9: normal fetch moves forward by the fetch width
    a_r9_fetch_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance_line && advance_fetch && !reverse)
        |=> addr == $past(addr) + STEP);

endmodule

// File: rtl/fbsa_ctrl.sv
module fbsa_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic cfg_fault,
    output logic walk_load,
    output logic scanning,
    output logic faulted
);
    import fbsa_pkg::*;

    fbsa_state_e state;
    fbsa_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (frame_start) state_nx = ST_LOAD;
            ST_LOAD:  begin
                if (frame_start)    state_nx = ST_LOAD;
                else if (cfg_fault) state_nx = ST_FAULT;
                else                state_nx = ST_SCAN;
            end
            ST_SCAN:  if (frame_start) state_nx = ST_LOAD;
            ST_FAULT: if (frame_start) state_nx = ST_LOAD;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        walk_load = (state == ST_LOAD);
        scanning  = (state == ST_SCAN);
        faulted   = (state == ST_FAULT);
    end

    // R7/R8: a rejected configuration ends in the fault state
    a_r7_fault_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !frame_start && cfg_fault) |=> state == ST_FAULT);

    // R11: frame start always leads to the load state
    a_r11_frame_to_load: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> state == ST_LOAD);

endmodule

// File: rtl/fb_scan_addr.sv
module fb_scan_addr #(
    parameter int ADDR_W     = 32,
    parameter int DIM_W      = 11,
    parameter int PITCH_W    = 16,
    parameter int ROT_LIMIT  = 320,
    parameter int ALIGN_BITS = 9,
    parameter int MAX_BYTES  = 2097152,
    parameter int STEP_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [DIM_W-1:0]   cfg_width,
    input  logic [DIM_W-1:0]   cfg_height,
    input  logic [DIM_W-1:0]   cfg_vtotal,
    input  logic [2:0]         cfg_depth,
    input  logic               cfg_gray,
    input  logic               cfg_rotate,
    input  logic               cfg_dual,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic               fetch_step,
    output logic [ADDR_W-1:0]  upper_addr,
    output logic [ADDR_W-1:0]  lower_addr,
    output logic               addr_valid,
    output logic [PITCH_W-1:0] line_pitch,
    output logic               rot_active,
    output logic               err_misalign,
    output logic               err_oversize
);
    // configuration sampled on frame start
    logic [ADDR_W-1:0] base_q;
    logic [DIM_W-1:0]  width_q, height_q, vtotal_q;
    logic [2:0]        depth_q;
    logic              gray_q, rotate_q, dual_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            width_q  <= '0;
            height_q <= '0;
            vtotal_q <= '0;
            depth_q  <= '0;
            gray_q   <= 1'b0;
            rotate_q <= 1'b0;
            dual_q   <= 1'b0;
        end else if (frame_start) begin
            base_q   <= cfg_base;
            width_q  <= cfg_width;
            height_q <= cfg_height;
            vtotal_q <= cfg_vtotal;
            depth_q  <= cfg_depth;
            gray_q   <= cfg_gray;
            rotate_q <= cfg_rotate;
            dual_q   <= cfg_dual;
        end
    end

    logic               rot_eff;
    logic [PITCH_W-1:0] pitch;
    logic [ADDR_W-1:0]  start_up, start_lo;
    logic               misalign, oversize;
    logic               walk_load, scanning, faulted;
    logic               adv_line, adv_fetch;
    logic [ADDR_W-1:0]  up_addr, lo_addr;

    fbsa_pitch #(
        .DIM_W(DIM_W), .PITCH_W(PITCH_W), .ROT_LIMIT(ROT_LIMIT)
    ) u_pitch (
        .width(width_q), .vtotal(vtotal_q), .depth(depth_q), .gray(gray_q),
        .rotate_req(rotate_q), .rot_eff(rot_eff), .pitch(pitch)
    );

    fbsa_origin #(
        .ADDR_W(ADDR_W), .DIM_W(DIM_W), .PITCH_W(PITCH_W),
        .ALIGN_BITS(ALIGN_BITS), .MAX_BYTES(MAX_BYTES)
    ) u_origin (
        .base(base_q), .width(width_q), .height(height_q), .pitch(pitch),
        .rot(rot_eff), .dual(dual_q), .start_up(start_up), .start_lo(start_lo),
        .misalign(misalign), .oversize(oversize)
    );

    fbsa_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_fault(misalign | oversize), .walk_load(walk_load),
        .scanning(scanning), .faulted(faulted)
    );

    // frame start outranks line start, which outranks fetch step
    assign adv_line  = scanning && !frame_start && line_start;
    assign adv_fetch = scanning && !frame_start && fetch_step;

    fbsa_walker #(
        .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .STEP_BYTES(STEP_BYTES)
    ) u_walk_up (
        .clk(clk), .rst_n(rst_n), .load(walk_load), .origin(start_up),
        .advance_line(adv_line), .advance_fetch(adv_fetch),
        .reverse(rot_eff), .pitch(pitch), .addr(up_addr)
    );

    fbsa_walker #(
        .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .STEP_BYTES(STEP_BYTES)
    ) u_walk_lo (
        .clk(clk), .rst_n(rst_n), .load(walk_load), .origin(start_lo),
        .advance_line(adv_line), .advance_fetch(adv_fetch),
        .reverse(rot_eff), .pitch(pitch), .addr(lo_addr)
    );

    always_comb begin
        addr_valid   = scanning;
        upper_addr   = scanning ? up_addr : '0;
        lower_addr   = (scanning && dual_q) ? lo_addr : '0;
        line_pitch   = scanning ? pitch : '0;
        rot_active   = scanning && rot_eff;
        err_misalign = faulted && misalign;
        err_oversize = faulted && oversize;
    end

    // R7/R8: no address is valid while a fault is reported
    a_r7_no_valid_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (err_misalign || err_oversize) |-> !addr_valid);

    // R3: a rotated scan always uses a power-of-two pitch
    a_r3_pitch_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        rot_active |-> $countones(line_pitch) == 1);

    // R11: a frame start removes validity at the next edge
    a_r11_frame_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !addr_valid);

    // R10: rotated fetch moves back by one pitch
    a_r10_fetch_back: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_active && fetch_step && !line_start && !frame_start)
        |=> upper_addr == $past(upper_addr) - ADDR_W'($past(line_pitch)));

    // R4: rotation never in effect on a wide line
    a_r4_wide_no_rot: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && int'(width_q) > ROT_LIMIT) |-> !rot_active);

endmodule

// File: tb/test_fb_scan_addr.sv
module test_fb_scan_addr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [10:0] cfg_width = '0, cfg_height = '0, cfg_vtotal = '0;
    logic [2:0]  cfg_depth = '0;
    logic        cfg_gray = 1'b0, cfg_rotate = 1'b0, cfg_dual = 1'b0;
    logic        frame_start = 1'b0, line_start = 1'b0, fetch_step = 1'b0;
    logic [31:0] upper_addr, lower_addr;
    logic        addr_valid, rot_active, err_misalign, err_oversize;
    logic [15:0] line_pitch;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;  // 250 MHz

    fb_scan_addr i_fb_scan_addr (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .cfg_vtotal(cfg_vtotal), .cfg_depth(cfg_depth),
        .cfg_gray(cfg_gray), .cfg_rotate(cfg_rotate), .cfg_dual(cfg_dual),
        .frame_start(frame_start), .line_start(line_start), .fetch_step(fetch_step),
        .upper_addr(upper_addr), .lower_addr(lower_addr), .addr_valid(addr_valid),
        .line_pitch(line_pitch), .rot_active(rot_active),
        .err_misalign(err_misalign), .err_oversize(err_oversize)
    );

    typedef struct packed {
        logic [10:0] w, h, vt;
        logic [2:0]  d;
        logic        g, r, dl;
        logic [31:0] pitch, up, lo;
        logic        rot;
    } vec_t;

    localparam logic [31:0] B = 32'h1000_0000;

    // R1, R2, R3, R4, R5, R6 vectors
    localparam vec_t VECS [0:8] = '{
        '{11'd320, 11'd240, 11'd262, 3'd3, 1'b0, 1'b0, 1'b0, 32'd320,  B,            32'h0,         1'b0}, // R1 8bpp
        '{11'd320, 11'd240, 11'd262, 3'd4, 1'b0, 1'b0, 1'b1, 32'd640,  B,            32'h1001_2C00, 1'b0}, // R1 16bpp R6 dual
        '{11'd640, 11'd480, 11'd500, 3'd0, 1'b1, 1'b0, 1'b0, 32'd80,   B,            32'h0,         1'b0}, // R2 1bpp
        '{11'd640, 11'd480, 11'd500, 3'd1, 1'b1, 1'b0, 1'b1, 32'd160,  B,            32'h1000_9600, 1'b0}, // R2 2bpp dual
        '{11'd640, 11'd480, 11'd500, 3'd2, 1'b1, 1'b0, 1'b0, 32'd320,  B,            32'h0,         1'b0}, // R2 4bpp
        '{11'd240, 11'd320, 11'd330, 3'd4, 1'b0, 1'b1, 1'b0, 32'd1024, 32'h1003_BC00, 32'h0,        1'b1}, // R3 round, R5
        '{11'd240, 11'd320, 11'd256, 3'd3, 1'b0, 1'b1, 1'b1, 32'd256,  32'h1000_EF00, 32'h1001_6700, 1'b1}, // R3 exact, R6 rot
        '{11'd640, 11'd480, 11'd500, 3'd3, 1'b0, 1'b1, 1'b0, 32'd640,  B,            32'h0,         1'b0}, // R4 ignored
        '{11'd320, 11'd240, 11'd262, 3'd2, 1'b0, 1'b0, 1'b0, 32'd320,  B,            32'h0,         1'b0}  // R1 4bpp colour
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [31:0] b, input logic [10:0] w, h, vt,
                           input logic [2:0] d, input logic g, r, dl);
        cfg_base = b; cfg_width = w; cfg_height = h; cfg_vtotal = vt;
        cfg_depth = d; cfg_gray = g; cfg_rotate = r; cfg_dual = dl;
    endtask

    // frame start sampled at one edge, scanning after the next
    task automatic start_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe(input logic ls, input logic fs);
        @(negedge clk); line_start = ls; fetch_step = fs;
        @(negedge clk); line_start = 1'b0; fetch_step = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        repeat (3) @(negedge clk);
        check("R12 valid in reset", {31'd0, addr_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R12 upper idle", upper_addr, 32'h0);
        check("R12 lower idle", lower_addr, 32'h0);
        check("R12 valid idle", {31'd0, addr_valid}, 32'd0);

        // R12 latency: not yet valid after the first edge
        set_cfg(B, 11'd320, 11'd240, 11'd262, 3'd3, 1'b0, 1'b0, 1'b0);
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        check("R12 valid after one edge", {31'd0, addr_valid}, 32'd0);
        @(negedge clk);
        check("R12 valid after two edges", {31'd0, addr_valid}, 32'd1);

        for (int i = 0; i < 9; i++) begin
            set_cfg(B, VECS[i].w, VECS[i].h, VECS[i].vt, VECS[i].d,
                    VECS[i].g, VECS[i].r, VECS[i].dl);
            start_frame();
            check($sformatf("R1/R2/R3 pitch vec%0d", i), {16'd0, line_pitch}, VECS[i].pitch);
            check($sformatf("R5 upper vec%0d", i), upper_addr, VECS[i].up);
            check($sformatf("R6 lower vec%0d", i), lower_addr, VECS[i].lo);
            check($sformatf("R4 rot vec%0d", i), {31'd0, rot_active}, {31'd0, VECS[i].rot});
        end

        // R9 normal walk, dual, pitch 640
        set_cfg(B, 11'd320, 11'd240, 11'd262, 3'd4, 1'b0, 1'b0, 1'b1);
        start_frame();
        strobe(1'b0, 1'b1);
        strobe(1'b0, 1'b1);
        check("R9 fetch upper", upper_addr, 32'h1000_0008);
        check("R9 fetch lower", lower_addr, 32'h1001_2C08);
        strobe(1'b1, 1'b0);
        check("R9 line upper", upper_addr, 32'h1000_0280);
        check("R9 line lower", lower_addr, 32'h1001_2E80);
        // R11 line beats fetch
        strobe(1'b1, 1'b1);
        check("R11 line over fetch", upper_addr, 32'h1000_0500);

        // R11 frame beats line
        @(negedge clk); frame_start = 1'b1; line_start = 1'b1;
        @(negedge clk); frame_start = 1'b0; line_start = 1'b0;
        check("R11 frame drops valid", {31'd0, addr_valid}, 32'd0);
        @(negedge clk);
        check("R11 frame reload", upper_addr, B);

        // R10 rotated walk, pitch 1024
        set_cfg(B, 11'd240, 11'd320, 11'd330, 3'd4, 1'b0, 1'b1, 1'b0);
        start_frame();
        strobe(1'b0, 1'b1);
        check("R10 fetch back", upper_addr, 32'h1003_B800);
        strobe(1'b1, 1'b0);
        check("R10 line fwd", upper_addr, 32'h1003_BC04);

        // R7 misaligned base
        set_cfg(32'h1000_0100, 11'd320, 11'd240, 11'd262, 3'd3, 1'b0, 1'b0, 1'b1);
        start_frame();
        check("R7 misalign flag", {31'd0, err_misalign}, 32'd1);
        check("R7 valid low", {31'd0, addr_valid}, 32'd0);
        check("R7 upper zero", upper_addr, 32'h0);
        check("R7 lower zero", lower_addr, 32'h0);
        strobe(1'b1, 1'b1);
        check("R7 strobes ignored", upper_addr, 32'h0);

        // R8 size limit: exactly at the limit, then one line more
        set_cfg(B, 11'd1024, 11'd1024, 11'd1030, 3'd4, 1'b0, 1'b0, 1'b0);
        start_frame();
        check("R8 at limit ok", {31'd0, err_oversize}, 32'd0);
        check("R8 at limit valid", {31'd0, addr_valid}, 32'd1);
        set_cfg(B, 11'd1024, 11'd1025, 11'd1030, 3'd4, 1'b0, 1'b0, 1'b0);
        start_frame();
        check("R8 oversize flag", {31'd0, err_oversize}, 32'd1);
        check("R8 pitch zero", {16'd0, line_pitch}, 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule